// File: doc/BRIEF.md
# Push-Button Single-Pulse Conditioner

This block turns a raw, asynchronous, mechanically bouncing push-button level into one clean event: a pulse that is high for exactly one clock cycle per physical press. The raw level first crosses into the clock domain through a chain of flip-flops. From then on, only the last flop of that chain feeds the qualification logic.

A press is accepted only after the synchronized level has stayed high for a programmable number of consecutive clock samples. The pulse fires at that moment. The block then stays silent for as long as the button is held. It re-arms only after the synchronized level has stayed low long enough to count as a real release. Short low blips during a hold are treated as contact bounce. A three-state machine (idle, held, release-qualifying) drives a single shared settle counter.

Top module: `btn_pulse_shaper`

## Requirements
- R1: The raw input passes through SYNC_STAGES (default 2) flip-flops, and only the last one feeds later logic. A raw level that is sampled high at clock edge k is first seen by the qualifier at edge k+2.
- R2: A press is accepted only when the synchronized input is high on SETTLE_CYCLES consecutive edges. A high run of SETTLE_CYCLES-1 produces no pulse.
- R3: Each accepted press produces exactly one pulse, one clock cycle wide. The raw input is first sampled high at edge 1. If it then stays high, the pulse is high in the cycle after edge SETTLE_CYCLES+2.
- R4: The button may be held for any length of time, and it still produces exactly one pulse.
- R5: After a pulse, the block re-arms only when the synchronized input is low on SETTLE_CYCLES+1 consecutive edges. The first of these leaves the held state, and the remaining SETTLE_CYCLES qualify the release. A shorter low gap, followed by high again, produces no second pulse.
- R6: Changes on the raw input that begin and end between two rising clock edges have no effect.
- R7: A synchronous active-high reset clears the synchronizer, the counter and the output, and returns the machine to idle. A button that is held through reset must then qualify from the beginning.
- R8: While idle, a single low sample inside a high run restarts the count. Two runs of SETTLE_CYCLES-1 high samples separated by one low sample give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw_i | input | 1 | Raw asynchronous button level, high when pressed |
| press_pulse_o | output | 1 | Registered one-cycle pulse per accepted press |

## Verification
The hardest case to reach from the ports is the re-arm boundary. The block is already in the held state, and it sees a low gap of exactly SETTLE_CYCLES samples or exactly one more before the button goes high again. Only the longer gap may produce a second pulse. The stimulus reaches this case with press/gap/press vectors whose gap lengths sit on each side of that boundary. A separate test toggles the raw input high and low within a single clock period, just after an edge, so that no edge ever samples the glitch.

// File: rtl/btn_cond_pkg.sv
package btn_cond_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HELD = 2'd1,
    ST_RELQ = 2'd2
  } press_state_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  // checker-only warm-up count of edges since reset
  logic [3:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)              warm_q <= '0;
    else if (warm_q < 4'd15) warm_q <= warm_q + 4'd1;
  end

  // R1: the output equals the raw level sampled STAGES edges earlier
  p_sync_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (int'(warm_q) >= STAGES) |-> (sync_o == $past(async_i, STAGES)));
endmodule

// File: rtl/btn_settle_counter.sv
module btn_settle_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  // R2: the count never passes the last qualifying value
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R7: reset leaves the counter at zero
  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/btn_press_fsm.sv
module btn_press_fsm
  import btn_cond_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic done_i,
  output logic clr_o,
  output logic inc_o,
  output logic pulse_o
);
  press_state_t st_q, st_d;
  logic         fire;

  always_comb begin
    st_d  = st_q;
    clr_o = 1'b0;
    inc_o = 1'b0;
    fire  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!level_i) begin
          clr_o = 1'b1;
        end else if (done_i) begin
          fire  = 1'b1;
          clr_o = 1'b1;
          st_d  = ST_HELD;
        end else begin
          inc_o = 1'b1;
        end
      end
      ST_HELD: begin
        clr_o = 1'b1;
        if (!level_i) st_d = ST_RELQ;
      end
      ST_RELQ: begin
        if (level_i) begin
          clr_o = 1'b1;
          st_d  = ST_HELD;
        end else if (done_i) begin
          clr_o = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          inc_o = 1'b1;
        end
      end
      default: begin
        clr_o = 1'b1;
        st_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pulse_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_o <= fire;
    end
  end

  // R3: a pulse never lasts two cycles
  p_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R2: a pulse follows a completed high count taken in idle
  p_fire_qualified_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> ($past(st_q) == ST_IDLE && $past(done_i) && $past(level_i)));
  // R4: outside idle no new pulse is produced
  p_no_refire_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> !pulse_o);
  // R5: idle is re-entered only from a completed low count
  p_rearm_qualified_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && $past(st_q) == ST_RELQ) |-> ($past(done_i) && !$past(level_i)));
  // R7: reset returns to idle with the output low
  p_reset_idle_r7: assert property (@(posedge clk)
    rst |=> (st_q == ST_IDLE && !pulse_o));
endmodule

// File: rtl/btn_pulse_shaper.sv
module btn_pulse_shaper #(
  parameter int SETTLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw_i,
  output logic press_pulse_o
);
  logic btn_level;
  logic cnt_clr, cnt_inc, cnt_done;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (btn_raw_i),
    .sync_o  (btn_level)
  );

  btn_settle_counter #(.LIMIT(SETTLE_CYCLES)) u_count (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .done_o (cnt_done)
  );

  btn_press_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .level_i (btn_level),
    .done_i  (cnt_done),
    .clr_o   (cnt_clr),
    .inc_o   (cnt_inc),
    .pulse_o (press_pulse_o)
  );

  // R6/R1: the output only moves on a clock edge after a settled input
  p_pulse_needs_level_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(press_pulse_o) |-> $past(btn_level));
endmodule

// File: tb/btn_pulse_shaper_test.sv
module btn_pulse_shaper_test;
  localparam int N    = 8;
  localparam int ROWS = 9;
  // stimulus: high run, low gap, second high run; expected pulses, first pulse index
  localparam int H1[ROWS]    = '{N-1, N,   5*N, N-1, N-1, 12, 12, 12, 1};
  localparam int GAP[ROWS]   = '{0,   0,   0,   1,   1,   N,  N+1, 3, 0};
  localparam int H2[ROWS]    = '{0,   0,   0,   N-1, N,   12, 12, 12, 0};
  localparam int ECNT[ROWS]  = '{0,   1,   1,   0,   1,   1,  2,  1,  0};
  localparam int EFIRST[ROWS]= '{-1,  N+2, N+2, -1,  2*N+2, N+2, N+2, N+2, -1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic pulse;
  int   runs = 0;
  int   fails = 0;
  bit   done_flag = 1'b0;

  always #4 clk = ~clk;

  btn_pulse_shaper #(.SETTLE_CYCLES(N), .SYNC_STAGES(2)) uut (
    .clk           (clk),
    .rst           (rst),
    .btn_raw_i     (btn),
    .press_pulse_o (pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string row_req(input int r);
    case (r)
      0: return "R2 short run";
      1: return "R2 R3 exact run";
      2: return "R4 long hold";
      3: return "R8 interrupted run";
      4: return "R8 restart then full run";
      5: return "R5 gap of N";
      6: return "R5 gap of N+1";
      7: return "R5 bounce gap";
      default: return "R2 single sample";
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      fails++;
      runs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    int cnt, first, prev, dbl, total;
    repeat (4) @(negedge clk);
    check(pulse == 1'b0, "R7 reset state", int'(pulse), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // table walk
    for (int r = 0; r < ROWS; r++) begin
      total = H1[r] + GAP[r] + H2[r] + 3*N + 6;
      cnt = 0; first = -1; prev = 0; dbl = 0;
      for (int k = 0; k < total; k++) begin
        @(negedge clk);
        if (pulse) begin
          cnt++;
          if (first < 0) first = k;
          if (prev) dbl++;
        end
        prev = int'(pulse);
        btn = (k < H1[r]) || (k >= H1[r] + GAP[r] && k < H1[r] + GAP[r] + H2[r]);
      end
      check(cnt == ECNT[r], row_req(r), cnt, ECNT[r]);
      check(first == EFIRST[r], {row_req(r), " timing R3"}, first, EFIRST[r]);
      check(dbl == 0, {row_req(r), " width R3"}, dbl, 0);
    end

    // R6: glitches that rise and fall between two edges
    cnt = 0;
    for (int k = 0; k < 4*N; k++) begin
      @(posedge clk);
      #1 btn = 1'b1;
      #2 btn = 1'b0;
      if (pulse) cnt++;
    end
    repeat (3*N) begin
      @(negedge clk);
      if (pulse) cnt++;
    end
    check(cnt == 0, "R6 intra-cycle glitch", cnt, 0);

    // R7: reset in the middle of a qualifying hold restarts qualification
    @(negedge clk);
    btn = 1'b1;
    cnt = 0;
    repeat (N - 2) begin
      @(negedge clk);
      if (pulse) cnt++;
    end
    rst = 1'b1;
    @(negedge clk);
    if (pulse) cnt++;
    rst = 1'b0;
    first = -1;
    for (int k = 0; k < 4*N; k++) begin
      @(negedge clk);
      if (pulse) begin
        cnt++;
        if (first < 0) first = k + 1;
      end
    end
    check(cnt == 1, "R7 pulses across reset", cnt, 1);
    check(first == N + 2, "R7 requalify after reset", first, N + 2);

    // R4 and R1: one more long hold after release
    btn = 1'b0;
    repeat (3*N) @(negedge clk);
    btn = 1'b1;
    cnt = 0; first = -1;
    for (int k = 1; k <= 10*N; k++) begin
      @(negedge clk);
      if (pulse) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
    check(cnt == 1, "R4 hold of 10N", cnt, 1);
    check(first == N + 2, "R1 sync latency", first, N + 2);
    btn = 1'b0;
    repeat (3*N) @(negedge clk);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule